// File: doc/BRIEF.md
# ATA Device Register File

This block is the device-side register file of an ATA programmed-I/O interface. A host reaches it through single-cycle read and write strobes with a 3-bit register offset. It holds the two cylinder/address bytes and presents the status byte on two offsets. One of those offsets acknowledges the pending interrupt and the other does not. A host write to the command offset is passed to an internal command engine as a one-cycle start pulse, together with the command byte and the address that was captured when the command was written.

The engine runs the command. It opens a data phase, and during that phase the host moves 16-bit words, or bytes carried in the low half of the word, through the data offset into or out of a one-sector buffer. The engine can also reach the same buffer through its own port. When the engine reports completion, the block copies the engine's current address into the cylinder bytes, records the error outcome and raises the interrupt. A starting cylinder that lies outside the configured cylinder count is refused at once with an error.

The host strobes carry no back-pressure. Every access completes in the cycle it is presented, and read data is valid combinationally in that cycle. The host must not assert read and write together.

Top module: `ata_taskfile`

## Requirements
- R1: After reset the status byte is 0x50 (ready and seek-complete set, all other bits clear), `intrq` is low, `cmd_start` is low and both cylinder bytes read 0x00.
- R2: The register offsets are 0 data, 4 cylinder low, 5 cylinder high, 6 alternate status (read only), 7 status on read and command on write. The status byte, from bit 7 down to bit 0, is busy, ready, device fault, seek complete, data request, corrected, index, error. While busy is clear, the cylinder bytes read back the low 8 bits last written to them, and offsets 1, 2 and 3 read 0.
- R3: A command write with starting address {high,low} below CYL_COUNT makes `cmd_start` high for exactly one cycle, beginning at the next edge. `cmd_code` carries the written byte and `cmd_addr` carries the address captured at the write. From that cycle busy is 1 and error is 0.
- R4: A command write with starting address at or above CYL_COUNT produces no start pulse. From the next cycle busy is 0, error is 1 and `intrq` is high.
- R5: While busy is 1, host writes to offsets 0, 4 and 5 are ignored, and a read of any offset returns the status byte.
- R6: An `eng_drq` pulse clears busy, sets data request and sets the buffer pointer to word 0. Each data-offset access while data request is set advances the pointer by one. The access that completes SECT_WORDS words clears data request and sets busy again. Busy and data request are never set together.
- R7: With `eng_byte` low at the `eng_drq` pulse, data words are 16 bits wide. With it high, a host write stores only bits 7:0 and zero-fills the upper byte, and a host read returns the stored low byte with bits 15:8 zero.
- R8: While data request is clear, a data-offset read returns 0x0000 and a data-offset write leaves the buffer unchanged.
- R9: An `eng_done` pulse clears busy and data request, sets error to `eng_err`, loads cylinder high and low from `eng_addr` bits 15:8 and 7:0, and raises the pending interrupt.
- R10: A read of offset 7 drops `intrq` in the same cycle as the strobe and clears the pending interrupt. A read of offset 6 returns the same byte and leaves the interrupt pending.
- R11: When a completion and an offset-7 read fall in the same cycle, `intrq` is low during that cycle and high from the next one.
- R12: The engine port reads the buffer word at `eng_buf_addr` combinationally and writes it when `eng_buf_we` is high. A host data write in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 3 | Register offset |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data (combinational) |
| intrq | output | 1 | Interrupt request to host |
| cmd_start | output | 1 | One-cycle command start to engine |
| cmd_code | output | 8 | Latched command byte |
| cmd_addr | output | 16 | Address captured at command write |
| eng_drq | input | 1 | Engine opens a data phase |
| eng_byte | input | 1 | Data phase uses byte transfers |
| eng_done | input | 1 | Engine completion pulse |
| eng_err | input | 1 | Completion ended with error |
| eng_addr | input | 16 | Engine current address at completion |
| eng_buf_we | input | 1 | Engine buffer write enable |
| eng_buf_addr | input | 8 | Engine buffer word index |
| eng_buf_wdata | input | 16 | Engine buffer write data |
| eng_buf_rdata | output | 16 | Engine buffer read data |

## Verification
Two functions can meet in one cycle. The first pair is the interrupt acknowledge caused by a status read and the completion that raises a new interrupt. The bench leaves an interrupt pending, starts a command, and then drives `eng_done` in the same cycle as an offset-7 read. It expects `intrq` low during that strobe and high on the following cycle, so the new event survives the acknowledge. The second pair is a host data write and an engine buffer write to the same word in one cycle. This case is judged by reading the word back through the engine port and expecting the host's value.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;
  localparam logic [2:0] OFS_DATA   = 3'd0;
  localparam logic [2:0] OFS_CYL_LO = 3'd4;
  localparam logic [2:0] OFS_CYL_HI = 3'd5;
  localparam logic [2:0] OFS_ALT    = 3'd6;
  localparam logic [2:0] OFS_STCMD  = 3'd7;

  typedef struct packed {
    logic busy;
    logic ready;
    logic fault;
    logic seek_ok;
    logic dreq;
    logic corr;
    logic index;
    logic error;
  } stat_t;
endpackage

// File: rtl/ata_tf_addr_regs.sv
module ata_tf_addr_regs #(
  parameter int CYL_COUNT = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lo_we,
  input  logic        hi_we,
  input  logic [7:0]  wdata,
  input  logic        cmd_we,
  input  logic        done,
  input  logic [15:0] cur_addr,
  output logic [7:0]  cyl_lo,
  output logic [7:0]  cyl_hi,
  output logic        cmd_accept,
  output logic        cmd_reject,
  output logic        cmd_start,
  output logic [7:0]  cmd_code,
  output logic [15:0] cmd_addr
);
  logic [31:0] start_full;
  logic        in_range;

  assign start_full = {16'd0, cyl_hi, cyl_lo};
  assign in_range   = start_full < 32'(CYL_COUNT);
  assign cmd_accept = cmd_we && in_range;
  assign cmd_reject = cmd_we && !in_range;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyl_lo <= '0;
      cyl_hi <= '0;
    end else if (done) begin
      cyl_lo <= cur_addr[7:0];
      cyl_hi <= cur_addr[15:8];
    end else begin
      if (lo_we) cyl_lo <= wdata;
      if (hi_we) cyl_hi <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_start <= 1'b0;
      cmd_code  <= '0;
      cmd_addr  <= '0;
    end else begin
      cmd_start <= cmd_accept;
      if (cmd_accept) begin
        cmd_code <= wdata;
        cmd_addr <= {cyl_hi, cyl_lo};
      end
    end
  end
endmodule

// File: rtl/ata_tf_status.sv
module ata_tf_status
  import ata_tf_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cmd_accept,
  input  logic  cmd_reject,
  input  logic  drq_open,
  input  logic  last_word,
  input  logic  done,
  input  logic  done_err,
  input  logic  ack,
  output logic  bsy,
  output logic  drq,
  output logic  irq_pend,
  output stat_t status
);
  logic err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bsy <= 1'b0;
      drq <= 1'b0;
      err <= 1'b0;
    end else if (cmd_accept) begin
      bsy <= 1'b1;
      drq <= 1'b0;
      err <= 1'b0;
    end else if (cmd_reject) begin
      bsy <= 1'b0;
      drq <= 1'b0;
      err <= 1'b1;
    end else if (drq_open) begin
      bsy <= 1'b0;
      drq <= 1'b1;
    end else if (last_word) begin
      bsy <= 1'b1;
      drq <= 1'b0;
    end else if (done) begin
      bsy <= 1'b0;
      drq <= 1'b0;
      err <= done_err;
    end
  end

  // a new event outranks an acknowledge in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) irq_pend <= 1'b0;
    else        irq_pend <= cmd_reject || done || (irq_pend && !ack);
  end

  always_comb begin
    status         = '0;
    status.busy    = bsy;
    status.ready   = 1'b1;
    status.seek_ok = 1'b1;
    status.dreq    = drq;
    status.error   = err;
  end
endmodule

// File: rtl/ata_tf_buffer.sv
module ata_tf_buffer #(
  parameter int WORDS = 256,
  parameter int W     = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     open,
  input  logic                     byte_in,
  input  logic                     acc,
  input  logic                     we,
  input  logic [W-1:0]             wdata,
  output logic [W-1:0]             rdata,
  output logic                     last,
  input  logic                     eng_we,
  input  logic [$clog2(WORDS)-1:0] eng_addr,
  input  logic [W-1:0]             eng_wdata,
  output logic [W-1:0]             eng_rdata
);
  localparam int PW   = $clog2(WORDS);
  localparam int HALF = W / 2;

  logic [W-1:0]  mem [WORDS];
  logic [PW-1:0] ptr;
  logic          byte_mode;
  logic [W-1:0]  wdata_m;
  logic [W-1:0]  word_at_ptr;

  assign word_at_ptr = mem[ptr];
  assign wdata_m     = byte_mode ? {{(W-HALF){1'b0}}, wdata[HALF-1:0]} : wdata;
  assign rdata       = byte_mode ? {{(W-HALF){1'b0}}, word_at_ptr[HALF-1:0]} : word_at_ptr;
  assign last        = acc && (ptr == PW'(WORDS - 1));
  assign eng_rdata   = mem[eng_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr       <= '0;
      byte_mode <= 1'b0;
    end else if (open) begin
      ptr       <= '0;
      byte_mode <= byte_in;
    end else if (acc) begin
      ptr <= ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (acc && we)   mem[ptr]      <= wdata_m;
    else if (eng_we) mem[eng_addr] <= eng_wdata;
  end
endmodule

// File: rtl/ata_taskfile.sv
module ata_taskfile
  import ata_tf_pkg::*;
#(
  parameter int SECT_WORDS = 256,
  parameter int CYL_COUNT  = 1000
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          host_rd,
  input  logic                          host_wr,
  input  logic [2:0]                    host_addr,
  input  logic [15:0]                   host_wdata,
  output logic [15:0]                   host_rdata,
  output logic                          intrq,
  output logic                          cmd_start,
  output logic [7:0]                    cmd_code,
  output logic [15:0]                   cmd_addr,
  input  logic                          eng_drq,
  input  logic                          eng_byte,
  input  logic                          eng_done,
  input  logic                          eng_err,
  input  logic [15:0]                   eng_addr,
  input  logic                          eng_buf_we,
  input  logic [$clog2(SECT_WORDS)-1:0] eng_buf_addr,
  input  logic [15:0]                   eng_buf_wdata,
  output logic [15:0]                   eng_buf_rdata
);
  logic        bsy, drq, irq_pend;
  stat_t       status;
  logic [7:0]  cyl_lo, cyl_hi;
  logic        cmd_accept, cmd_reject;
  logic        lo_we, hi_we, cmd_we, data_acc, stat_ack, last_word;
  logic [15:0] buf_rdata;

  assign cmd_we   = host_wr && (host_addr == OFS_STCMD);
  assign lo_we    = host_wr && (host_addr == OFS_CYL_LO) && !bsy;
  assign hi_we    = host_wr && (host_addr == OFS_CYL_HI) && !bsy;
  assign data_acc = (host_rd || host_wr) && (host_addr == OFS_DATA) && drq;
  assign stat_ack = host_rd && (host_addr == OFS_STCMD);
  assign intrq    = irq_pend && !stat_ack;

  ata_tf_addr_regs #(.CYL_COUNT(CYL_COUNT)) u_regs (
    .clk(clk), .rst_n(rst_n), .lo_we(lo_we), .hi_we(hi_we),
    .wdata(host_wdata[7:0]), .cmd_we(cmd_we), .done(eng_done),
    .cur_addr(eng_addr), .cyl_lo(cyl_lo), .cyl_hi(cyl_hi),
    .cmd_accept(cmd_accept), .cmd_reject(cmd_reject),
    .cmd_start(cmd_start), .cmd_code(cmd_code), .cmd_addr(cmd_addr)
  );

  ata_tf_status u_stat (
    .clk(clk), .rst_n(rst_n), .cmd_accept(cmd_accept), .cmd_reject(cmd_reject),
    .drq_open(eng_drq), .last_word(last_word), .done(eng_done),
    .done_err(eng_err), .ack(stat_ack), .bsy(bsy), .drq(drq),
    .irq_pend(irq_pend), .status(status)
  );

  ata_tf_buffer #(.WORDS(SECT_WORDS), .W(16)) u_buf (
    .clk(clk), .rst_n(rst_n), .open(eng_drq), .byte_in(eng_byte),
    .acc(data_acc), .we(host_wr), .wdata(host_wdata), .rdata(buf_rdata),
    .last(last_word), .eng_we(eng_buf_we), .eng_addr(eng_buf_addr),
    .eng_wdata(eng_buf_wdata), .eng_rdata(eng_buf_rdata)
  );

  always_comb begin
    host_rdata = '0;
    if (bsy) begin
      host_rdata = {8'h00, status};
    end else begin
      case (host_addr)
        OFS_DATA:   host_rdata = drq ? buf_rdata : 16'h0000;
        OFS_CYL_LO: host_rdata = {8'h00, cyl_lo};
        OFS_CYL_HI: host_rdata = {8'h00, cyl_hi};
        OFS_ALT,
        OFS_STCMD:  host_rdata = {8'h00, status};
        default:    host_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/ata_taskfile_chk.sv
module ata_taskfile_chk #(
  parameter int CYL_COUNT = 1000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       host_rd,
  input logic       host_wr,
  input logic [2:0] host_addr,
  input logic       intrq,
  input logic       cmd_start,
  input logic       eng_done,
  input logic       bsy,
  input logic       drq,
  input logic       irq_pend,
  input logic [7:0] cyl_lo,
  input logic [7:0] cyl_hi,
  input logic [7:0] status_b
);
  logic bad_cmd;
  assign bad_cmd = host_wr && (host_addr == 3'd7) &&
                   ({16'd0, cyl_hi, cyl_lo} >= 32'(CYL_COUNT));

  p_start_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> !cmd_start);
  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |-> bsy);
  p_reject_no_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bad_cmd |=> (!cmd_start && status_b[0] && intrq));
  p_busy_write_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bsy && host_wr && host_addr == 3'd4 && !eng_done) |=> $stable(cyl_lo));
  p_busy_drq_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bsy && drq));
  p_done_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> irq_pend);
  p_ack_masks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == 3'd7) |-> !intrq);
  p_alt_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == 3'd6 && irq_pend) |=> irq_pend);
endmodule

bind ata_taskfile ata_taskfile_chk #(.CYL_COUNT(CYL_COUNT)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_wr(host_wr),
  .host_addr(host_addr), .intrq(intrq), .cmd_start(cmd_start),
  .eng_done(eng_done), .bsy(bsy), .drq(drq), .irq_pend(irq_pend),
  .cyl_lo(cyl_lo), .cyl_hi(cyl_hi), .status_b(status)
);

// File: tb/ata_taskfile_test.sv
module ata_taskfile_test;
  localparam int WORDS = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_rd = 1'b0, host_wr = 1'b0;
  logic [2:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        intrq, cmd_start;
  logic [7:0]  cmd_code;
  logic [15:0] cmd_addr;
  logic        eng_drq = 1'b0, eng_byte = 1'b0, eng_done = 1'b0, eng_err = 1'b0;
  logic [15:0] eng_addr = '0;
  logic        eng_buf_we = 1'b0;
  logic [7:0]  eng_buf_addr = '0;
  logic [15:0] eng_buf_wdata = '0;
  logic [15:0] eng_buf_rdata;

  int n_tests = 0;
  int n_fail  = 0;
  logic [15:0] rd_val;
  logic        rd_irq;

  always #5 clk = ~clk;

  ata_taskfile #(.SECT_WORDS(WORDS), .CYL_COUNT(1000)) uut (
    .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .intrq(intrq), .cmd_start(cmd_start), .cmd_code(cmd_code), .cmd_addr(cmd_addr),
    .eng_drq(eng_drq), .eng_byte(eng_byte), .eng_done(eng_done), .eng_err(eng_err),
    .eng_addr(eng_addr), .eng_buf_we(eng_buf_we), .eng_buf_addr(eng_buf_addr),
    .eng_buf_wdata(eng_buf_wdata), .eng_buf_rdata(eng_buf_rdata)
  );

  // {write, offset, write data, expected read data}
  localparam logic [35:0] VEC [0:10] = '{
    {1'b0, 3'd7, 16'h0000, 16'h0050},  // R1 status after reset
    {1'b1, 3'd4, 16'h0012, 16'h0000},
    {1'b1, 3'd5, 16'h0003, 16'h0000},
    {1'b0, 3'd4, 16'h0000, 16'h0012},  // R2 readback
    {1'b0, 3'd5, 16'h0000, 16'h0003},
    {1'b0, 3'd6, 16'h0000, 16'h0050},  // R2 alternate status
    {1'b0, 3'd0, 16'h0000, 16'h0000},  // R8 data read without request
    {1'b1, 3'd4, 16'hAAFF, 16'h0000},
    {1'b0, 3'd4, 16'h0000, 16'h00FF},  // R2 low byte kept
    {1'b1, 3'd0, 16'hBEEF, 16'h0000},  // R8 data write without request
    {1'b0, 3'd3, 16'h0000, 16'h0000}   // R2 unmapped offset
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic host_read(input logic [2:0] a);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    #2;
    rd_val = host_rdata; rd_irq = intrq;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic eng_open(input logic b);
    @(negedge clk);
    eng_drq = 1'b1; eng_byte = b;
    @(negedge clk);
    eng_drq = 1'b0;
  endtask

  task automatic eng_finish(input logic e, input logic [15:0] a);
    @(negedge clk);
    eng_done = 1'b1; eng_err = e; eng_addr = a;
    @(negedge clk);
    eng_done = 1'b0;
  endtask

  task automatic eng_peek(input logic [7:0] a, input string req, input logic [15:0] exp);
    @(negedge clk);
    eng_buf_addr = a;
    #1;
    chk(req, eng_buf_rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 intrq", {15'd0, intrq}, 16'd0);
    chk("R1 cmd_start", {15'd0, cmd_start}, 16'd0);

    // engine writes word 0 (R12)
    @(negedge clk);
    eng_buf_we = 1'b1; eng_buf_addr = 8'd0; eng_buf_wdata = 16'h1111;
    @(negedge clk);
    eng_buf_we = 1'b0;

    for (int i = 0; i < 11; i++) begin
      if (VEC[i][35]) host_write(VEC[i][34:32], VEC[i][31:16]);
      else begin
        host_read(VEC[i][34:32]);
        chk($sformatf("R2 vector %0d", i), rd_val, VEC[i][15:0]);
      end
    end
    eng_peek(8'd0, "R8 buffer untouched", 16'h1111);
    eng_peek(8'd0, "R12 engine write", 16'h1111);

    // cylinder 0x03FF is out of range (R4)
    host_write(3'd7, 16'h0020);
    chk("R4 no start", {15'd0, cmd_start}, 16'd0);
    chk("R4 intrq raised", {15'd0, intrq}, 16'd1);
    host_read(3'd7);
    chk("R4 status err", rd_val, 16'h0051);
    chk("R10 ack same cycle", {15'd0, rd_irq}, 16'd0);
    chk("R10 intrq cleared", {15'd0, intrq}, 16'd0);

    // valid command (R3) and busy behaviour (R5)
    host_write(3'd4, 16'h0034);
    host_write(3'd5, 16'h0002);
    host_write(3'd7, 16'h0030);
    chk("R3 start", {15'd0, cmd_start}, 16'd1);
    chk("R3 code", {8'd0, cmd_code}, 16'h0030);
    chk("R3 addr", cmd_addr, 16'h0234);
    @(negedge clk);
    chk("R3 single pulse", {15'd0, cmd_start}, 16'd0);
    host_read(3'd7);
    chk("R3 busy status", rd_val, 16'h00D0);
    host_write(3'd4, 16'h0077);
    host_read(3'd4);
    chk("R5 read returns status", rd_val, 16'h00D0);
    host_read(3'd0);
    chk("R5 data read returns status", rd_val, 16'h00D0);

    // word write phase (R6, R7)
    eng_open(1'b0);
    host_read(3'd7);
    chk("R6 drq status", rd_val, 16'h0058);
    host_read(3'd4);
    chk("R5 busy write ignored", rd_val, 16'h0034);
    for (int i = 0; i < WORDS; i++) begin
      host_write(3'd0, 16'(16'h4000 + i * 7));
      if (i == WORDS - 2) begin
        host_read(3'd7);
        chk("R6 drq before last", rd_val, 16'h0058);
      end
    end
    host_read(3'd7);
    chk("R6 busy after last", rd_val, 16'h00D0);
    eng_peek(8'd5, "R7 word write", 16'h4023);
    eng_peek(8'd255, "R7 last word", 16'h46F9);

    eng_finish(1'b0, 16'h0255);
    chk("R9 intrq", {15'd0, intrq}, 16'd1);
    host_read(3'd4);
    chk("R9 cyl low", rd_val, 16'h0055);
    host_read(3'd5);
    chk("R9 cyl high", rd_val, 16'h0002);
    host_read(3'd7);
    chk("R9 status", rd_val, 16'h0050);

    // word read phase
    host_write(3'd7, 16'h0020);
    eng_open(1'b0);
    for (int i = 0; i < WORDS; i++) begin
      host_read(3'd0);
      chk($sformatf("R6 read word %0d", i), rd_val, 16'(16'h4000 + i * 7));
    end
    host_read(3'd7);
    chk("R6 busy after read", rd_val, 16'h00D0);
    eng_finish(1'b0, 16'h0256);
    host_read(3'd7);

    // byte phase (R7)
    host_write(3'd7, 16'h0031);
    eng_open(1'b1);
    host_write(3'd0, 16'h12CD);
    for (int i = 1; i < WORDS; i++) host_write(3'd0, 16'hFFFF);
    eng_peek(8'd0, "R7 byte write low only", 16'h00CD);
    eng_peek(8'd1, "R7 byte write upper zero", 16'h00FF);
    eng_finish(1'b1, 16'h0010);
    host_read(3'd6);
    chk("R10 alt status", rd_val, 16'h0051);
    chk("R10 alt keeps intrq", {15'd0, rd_irq}, 16'd1);
    chk("R10 intrq after alt", {15'd0, intrq}, 16'd1);
    host_read(3'd4);
    chk("R9 err cyl low", rd_val, 16'h0010);

    // completion and acknowledge in one cycle (R11)
    host_write(3'd7, 16'h0030);
    chk("R11 pending kept", {15'd0, intrq}, 16'd1);
    @(negedge clk);
    host_rd = 1'b1; host_addr = 3'd7;
    eng_done = 1'b1; eng_err = 1'b0; eng_addr = 16'h0010;
    #2;
    chk("R11 masked during ack", {15'd0, intrq}, 16'd0);
    @(negedge clk);
    host_rd = 1'b0; eng_done = 1'b0;
    #1;
    chk("R11 new interrupt", {15'd0, intrq}, 16'd1);
    host_read(3'd7);
    chk("R11 status", rd_val, 16'h0050);

    // host and engine write same word (R12)
    host_write(3'd7, 16'h0030);
    eng_open(1'b0);
    @(negedge clk);
    host_wr = 1'b1; host_addr = 3'd0; host_wdata = 16'hAAAA;
    eng_buf_we = 1'b1; eng_buf_addr = 8'd0; eng_buf_wdata = 16'h5555;
    @(negedge clk);
    host_wr = 1'b0; eng_buf_we = 1'b0;
    eng_peek(8'd0, "R12 host wins", 16'hAAAA);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule